// File: doc/BRIEF.md
# Register Alias Table with Readiness

This block keeps, for each of eight logical registers, the physical tag of the in-flight instruction that will produce its next value, together with a flag saying whether that value has already been written back. An issuing instruction looks up the tags and readiness of up to two source registers through combinational read ports. In the same cycle it can claim its destination register for a newly allocated tag, which marks that register as not ready.

Readiness and release are both found by comparing tags against every entry at once, not by indexed writes. Three writeback buses (two ALUs and the memory unit) each present a tag. Every mapped entry holding a presented tag becomes ready. A retire port presents the tag of the oldest completing instruction. Every mapped entry holding that tag is released, so the register reads from the architectural file again. An unmapped register reads as ready, with tag zero.

Top module: `reg_alias_table`

## Requirements
- R1: After reset every register is unmapped; a lookup of any register returns mapped 0, ready 1 and tag 0.
- R2: When `iss_valid` is 1, from the next cycle the register `iss_dst` reads mapped 1, tag `iss_tag` and ready 0. Other registers are unchanged.
- R3: Lookups are combinational from the stored state at the start of the cycle. A source equal to the same cycle's destination returns the old mapping.
- R4: When `wb_valid[j]` is 1, every mapped register whose stored tag equals bus j's tag (bits `wb_tag[j*5 +: 5]`; bus 0 and bus 1 are the ALUs, bus 2 is memory) reads ready 1 from the next cycle. Registers holding other tags are unaffected. Once ready, a mapped register stays ready with the same tag until it is re-issued or released.
- R5: When `ret_valid` is 1, every mapped register whose stored tag equals `ret_tag` reads unmapped (mapped 0, ready 1, tag 0) from the next cycle. A non-matching retire has no effect.
- R6: If an issue and a matching writeback hit the same register in one cycle, the issue wins: the new tag is stored and ready is 0.
- R7: If an issue and a matching retire hit the same register in one cycle, the issue wins: the register is mapped to the new tag.
- R8: A writeback bus with its valid bit at 0, or a retire with `ret_valid` at 0, changes nothing, whatever tag it carries.
- R9: An unmapped register stays unmapped under any writeback or retire. Only an issue maps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Destination allocation this cycle |
| iss_dst | input | 3 | Destination logical register |
| iss_tag | input | 5 | Newly allocated physical tag |
| iss_src_a | input | 3 | First source register to look up |
| iss_src_b | input | 3 | Second source register to look up |
| src_a_mapped | output | 1 | First source has an in-flight producer |
| src_a_ready | output | 1 | First source value is available |
| src_a_tag | output | 5 | First source physical tag (0 when unmapped) |
| src_b_mapped | output | 1 | Second source has an in-flight producer |
| src_b_ready | output | 1 | Second source value is available |
| src_b_tag | output | 5 | Second source physical tag (0 when unmapped) |
| wb_valid | input | 3 | Per-bus writeback valid |
| wb_tag | input | 15 | Writeback tags, 5 bits per bus |
| ret_valid | input | 1 | Retirement this cycle |
| ret_tag | input | 5 | Tag of the retiring instruction |

## Verification
The assertions assume that all inputs are known after reset and that at most one destination is claimed per cycle. They make no assumption that writeback or retire tags correspond to issued tags, so stale and unknown tags are legal. The bench therefore drives stale tags, unmatched tags, and tags shared by two registers on purpose. It changes inputs only on falling edges and keeps to a single issue per cycle.

// File: rtl/reg_alias_table.sv
module reg_alias_table #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 5,
  parameter int NUM_WB   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [$clog2(NUM_REGS)-1:0] iss_dst,
  input  logic [TAG_W-1:0]        iss_tag,
  input  logic [$clog2(NUM_REGS)-1:0] iss_src_a,
  input  logic [$clog2(NUM_REGS)-1:0] iss_src_b,
  output logic                    src_a_mapped,
  output logic                    src_a_ready,
  output logic [TAG_W-1:0]        src_a_tag,
  output logic                    src_b_mapped,
  output logic                    src_b_ready,
  output logic [TAG_W-1:0]        src_b_tag,
  input  logic [NUM_WB-1:0]       wb_valid,
  input  logic [NUM_WB*TAG_W-1:0] wb_tag,
  input  logic                    ret_valid,
  input  logic [TAG_W-1:0]        ret_tag
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0]            mapped_q;
  logic [NUM_REGS-1:0]            ready_q;
  logic [NUM_REGS-1:0][TAG_W-1:0] tag_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    logic iss_hit, ret_hit, wb_hit;

    assign iss_hit = iss_valid && (iss_dst == IDX_W'(i));
    assign ret_hit = ret_valid && mapped_q[i] && (tag_q[i] == ret_tag);

    always_comb begin
      wb_hit = 1'b0;
      for (int j = 0; j < NUM_WB; j++)
        if (wb_valid[j] && wb_tag[j*TAG_W +: TAG_W] == tag_q[i]) wb_hit = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mapped_q[i] <= 1'b0;
        ready_q[i]  <= 1'b1;
        tag_q[i]    <= '0;
      end else if (iss_hit) begin
        mapped_q[i] <= 1'b1;
        ready_q[i]  <= 1'b0;
        tag_q[i]    <= iss_tag;
      end else if (ret_hit) begin
        mapped_q[i] <= 1'b0;
        ready_q[i]  <= 1'b1;
      end else if (wb_hit && mapped_q[i]) begin
        ready_q[i]  <= 1'b1;
      end
    end
  end

  assign src_a_mapped = mapped_q[iss_src_a];
  assign src_a_ready  = ready_q[iss_src_a] | ~mapped_q[iss_src_a];
  assign src_a_tag    = mapped_q[iss_src_a] ? tag_q[iss_src_a] : '0;
  assign src_b_mapped = mapped_q[iss_src_b];
  assign src_b_ready  = ready_q[iss_src_b] | ~mapped_q[iss_src_b];
  assign src_b_tag    = mapped_q[iss_src_b] ? tag_q[iss_src_b] : '0;
endmodule

// File: rtl/reg_alias_table_chk.sv
module reg_alias_table_chk #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 5,
  parameter int NUM_WB   = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         iss_valid,
  input logic [$clog2(NUM_REGS)-1:0]  iss_dst,
  input logic [TAG_W-1:0]             iss_tag,
  input logic [NUM_WB-1:0]            wb_valid,
  input logic [NUM_WB*TAG_W-1:0]      wb_tag,
  input logic                         ret_valid,
  input logic [TAG_W-1:0]             ret_tag,
  input logic [NUM_REGS-1:0]          mapped_q,
  input logic [NUM_REGS-1:0]          ready_q,
  input logic [NUM_REGS-1:0][TAG_W-1:0] tag_q
);
  localparam int IDX_W = $clog2(NUM_REGS);

  AST_RESET_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mapped_q == '0)); // R1

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    logic own, rmatch, wmatch;
    assign own    = iss_valid && (iss_dst == IDX_W'(i));
    assign rmatch = ret_valid && (tag_q[i] == ret_tag);
    always_comb begin
      wmatch = 1'b0;
      for (int j = 0; j < NUM_WB; j++)
        if (wb_valid[j] && wb_tag[j*TAG_W +: TAG_W] == tag_q[i]) wmatch = 1'b1;
    end

    AST_ISSUE_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
      own |=> mapped_q[i] && !ready_q[i] && tag_q[i] == $past(iss_tag)); // R2

    AST_RETIRE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (!own && mapped_q[i] && rmatch) |=> !mapped_q[i]); // R5

    AST_WB_READIES: assert property (@(posedge clk) disable iff (!rst_n)
      (!own && mapped_q[i] && !rmatch && wmatch) |=> mapped_q[i] && ready_q[i]); // R4

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!own && mapped_q[i] && ready_q[i] && !rmatch) |=>
        mapped_q[i] && ready_q[i] && $stable(tag_q[i])); // R4

    AST_UNMAPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!own && !mapped_q[i]) |=> !mapped_q[i]); // R9
  end
endmodule

bind reg_alias_table reg_alias_table_chk #(
  .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .NUM_WB(NUM_WB)
) i_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
  .iss_tag(iss_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
  .ret_valid(ret_valid), .ret_tag(ret_tag), .mapped_q(mapped_q),
  .ready_q(ready_q), .tag_q(tag_q)
);

// File: tb/test_reg_alias_table.sv
`timescale 1ns/1ps
module test_reg_alias_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
  logic [4:0]  iss_tag = '0;
  logic        src_a_mapped, src_a_ready, src_b_mapped, src_b_ready;
  logic [4:0]  src_a_tag, src_b_tag;
  logic [2:0]  wb_valid = '0;
  logic [14:0] wb_tag = '0;
  logic        ret_valid = 1'b0;
  logic [4:0]  ret_tag = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reg_alias_table i_reg_alias_table (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_tag(iss_tag), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .src_a_mapped(src_a_mapped), .src_a_ready(src_a_ready), .src_a_tag(src_a_tag),
    .src_b_mapped(src_b_mapped), .src_b_ready(src_b_ready), .src_b_tag(src_b_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .ret_valid(ret_valid), .ret_tag(ret_tag)
  );

  // {iss_v, dst, tag, wb_v, wb0, wb1, wb2, ret_v, ret_tag, chk_reg, exp_m, exp_r, exp_t}
  localparam int NV = 16;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1,3'd2,5'd7,  3'b000,5'd0, 5'd0, 5'd0,  1'b0,5'd0,  3'd2, 1'b1,1'b0,5'd7},
    {1'b1,3'd3,5'd9,  3'b000,5'd0, 5'd0, 5'd0,  1'b0,5'd0,  3'd2, 1'b1,1'b0,5'd7},
    {1'b0,3'd0,5'd0,  3'b001,5'd7, 5'd0, 5'd0,  1'b0,5'd0,  3'd2, 1'b1,1'b1,5'd7},
    {1'b0,3'd0,5'd0,  3'b010,5'd0, 5'd9, 5'd0,  1'b0,5'd0,  3'd3, 1'b1,1'b1,5'd9},
    {1'b1,3'd5,5'd12, 3'b000,5'd0, 5'd0, 5'd0,  1'b0,5'd0,  3'd5, 1'b1,1'b0,5'd12},
    {1'b0,3'd0,5'd0,  3'b100,5'd0, 5'd0, 5'd12, 1'b0,5'd0,  3'd5, 1'b1,1'b1,5'd12},
    {1'b1,3'd6,5'd20, 3'b000,5'd0, 5'd0, 5'd0,  1'b0,5'd0,  3'd6, 1'b1,1'b0,5'd20},
    {1'b0,3'd0,5'd0,  3'b000,5'd20,5'd20,5'd20, 1'b0,5'd0,  3'd6, 1'b1,1'b0,5'd20},
    {1'b0,3'd0,5'd0,  3'b010,5'd0, 5'd21,5'd0,  1'b0,5'd0,  3'd6, 1'b1,1'b0,5'd20},
    {1'b0,3'd0,5'd0,  3'b000,5'd0, 5'd0, 5'd0,  1'b1,5'd7,  3'd2, 1'b0,1'b1,5'd0},
    {1'b0,3'd0,5'd0,  3'b000,5'd0, 5'd0, 5'd0,  1'b0,5'd9,  3'd3, 1'b1,1'b1,5'd9},
    {1'b0,3'd0,5'd0,  3'b000,5'd0, 5'd0, 5'd0,  1'b1,5'd30, 3'd3, 1'b1,1'b1,5'd9},
    {1'b1,3'd1,5'd4,  3'b000,5'd0, 5'd0, 5'd0,  1'b0,5'd0,  3'd1, 1'b1,1'b0,5'd4},
    {1'b1,3'd1,5'd11, 3'b011,5'd4, 5'd11,5'd0,  1'b0,5'd0,  3'd1, 1'b1,1'b0,5'd11},
    {1'b1,3'd3,5'd15, 3'b000,5'd0, 5'd0, 5'd0,  1'b1,5'd9,  3'd3, 1'b1,1'b0,5'd15},
    {1'b0,3'd0,5'd0,  3'b001,5'd9, 5'd0, 5'd0,  1'b0,5'd0,  3'd3, 1'b1,1'b0,5'd15}
  };
  localparam string VREQ [NV] = '{"R2","R2","R4","R4","R2","R4","R2","R8",
                                  "R4","R5","R8","R5","R2","R6","R7","R4"};

  task automatic clear_inputs();
    iss_valid = 1'b0; wb_valid = '0; wb_tag = '0; ret_valid = 1'b0; ret_tag = '0;
  endtask

  task automatic check_a(input string req, input logic m, input logic r, input logic [4:0] t);
    checks++;
    if ({src_a_mapped, src_a_ready, src_a_tag} !== {m, r, t}) begin
      fails++;
      $display("FAIL %s reg %0d: got m=%b r=%b t=%0d, expected m=%b r=%b t=%0d",
               req, iss_src_a, src_a_mapped, src_a_ready, src_a_tag, m, r, t);
    end
  endtask

  task automatic check_b(input string req, input logic m, input logic r, input logic [4:0] t);
    checks++;
    if ({src_b_mapped, src_b_ready, src_b_tag} !== {m, r, t}) begin
      fails++;
      $display("FAIL %s reg %0d (port b): got m=%b r=%b t=%0d, expected m=%b r=%b t=%0d",
               req, iss_src_b, src_b_mapped, src_b_ready, src_b_tag, m, r, t);
    end
  endtask

  task automatic issue(input logic [2:0] d, input logic [4:0] t);
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = d; iss_tag = t;
    @(negedge clk);
    clear_inputs();
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state on every register, both ports
    for (int k = 0; k < 8; k++) begin
      iss_src_a = 3'(k); iss_src_b = 3'(7 - k);
      #0.5;
      check_a("R1", 1'b0, 1'b1, 5'd0);
      check_b("R1", 1'b0, 1'b1, 5'd0);
    end
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      iss_valid = VEC[v][42]; iss_dst = VEC[v][41:39]; iss_tag = VEC[v][38:34];
      wb_valid = VEC[v][33:31];
      wb_tag = {VEC[v][20:16], VEC[v][25:21], VEC[v][30:26]};
      ret_valid = VEC[v][15]; ret_tag = VEC[v][14:10];
      @(negedge clk);
      clear_inputs();
      iss_src_a = VEC[v][9:7];
      #0.5;
      check_a(VREQ[v], VEC[v][6], VEC[v][5], VEC[v][4:0]);
    end

    // R3: same-cycle source lookup sees the old mapping of the destination
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = 3'd3; iss_tag = 5'd22; iss_src_a = 3'd3;
    #0.5;
    check_a("R3", 1'b1, 1'b0, 5'd15);
    @(negedge clk);
    clear_inputs();
    #0.5;
    check_a("R3", 1'b1, 1'b0, 5'd22);

    // R4 and R5: one tag held by two registers is matched in both
    issue(3'd4, 5'd16);
    issue(3'd7, 5'd16);
    wb_valid = 3'b100; wb_tag = {5'd16, 5'd0, 5'd0};
    @(negedge clk);
    clear_inputs();
    iss_src_a = 3'd4; iss_src_b = 3'd7;
    #0.5;
    check_a("R4", 1'b1, 1'b1, 5'd16);
    check_b("R4", 1'b1, 1'b1, 5'd16);
    @(negedge clk);
    ret_valid = 1'b1; ret_tag = 5'd16;
    @(negedge clk);
    clear_inputs();
    #0.5;
    check_a("R5", 1'b0, 1'b1, 5'd0);
    check_b("R5", 1'b0, 1'b1, 5'd0);

    // R9: unmapped registers ignore writeback and retire, including stale tags
    @(negedge clk);
    wb_valid = 3'b111; wb_tag = {5'd7, 5'd0, 5'd16};
    ret_valid = 1'b1; ret_tag = 5'd0;
    @(negedge clk);
    clear_inputs();
    iss_src_a = 3'd0; iss_src_b = 3'd2;
    #0.5;
    check_a("R9", 1'b0, 1'b1, 5'd0);
    check_b("R9", 1'b0, 1'b1, 5'd0);

    // R1: a second reset releases live mappings
    iss_src_a = 3'd3; iss_src_b = 3'd6;
    rst_n = 1'b0;
    #0.5;
    check_a("R1", 1'b0, 1'b1, 5'd0);
    check_b("R1", 1'b0, 1'b1, 5'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule